// File: doc/BRIEF.md
# Amplifier power mode sequencer

This block sequences the operating modes of a class-D audio output stage. It decides in which cycles the output stage is allowed to switch. It also tells the downstream volume logic whether the volume should head for its programmed value or for minimum. Its inputs are four kinds of request: shutdown (from a pin or from a register bit), fault, sleep and mute. Each request moves the block along its own timed path.

All delays are counted in pulses of an external one-millisecond strobe, so the block can run from any system clock. Entering shutdown or sleep first lowers the volume over a ramp time and holds switching for one extra strobe before stopping. Coming out of shutdown takes a long power-up delay, while coming out of sleep takes a short wake delay. Mute only moves the volume and never stops switching.

Faults stop switching at once and hold the stage off for a time that depends on the fault class. During that hold the active-low fault output is driven low. When the hold ends, a retry begins through the wake delay. Over-temperature is derived from a temperature code using a trip level and a hysteresis band.

Top module: `amp_mode_seq`

## Requirements
- R1: While reset is high and in the first cycle after it, sw_en and vol_up are 0 and fault_n is 1, and the block is in shutdown.
- R2: Shutdown is requested when shdn_pin_n is 0 or shdn_reg_n is 0. With either at 0, sw_en stays 0. After both go to 1, sw_en and vol_up rise on the clock edge that samples the ACTIVE_TICKS-th ms_tick after the release edge.
- R3: When shutdown is requested while the stage plays, vol_up goes to 0 on the next edge. sw_en stays 1 and then falls on the edge that samples the (RAMP_TICKS+GUARD_TICKS)-th tick.
- R4: Asserting sleep_req while the stage plays follows the same path as R3: vol_up falls on the next edge, and sw_en falls after RAMP_TICKS+GUARD_TICKS ticks.
- R5: Once the stage is asleep, releasing sleep_req raises sw_en and vol_up on the edge that samples the WAKE_TICKS-th tick.
- R6: While the stage plays, vol_up equals the inverse of mute_req one edge later, and mute_req never clears sw_en.
- R7: A dc_err pulse while the stage plays clears sw_en and vol_up and drives fault_n to 0 on the next edge. fault_n returns to 1 after DC_HOLD_TICKS ticks, and the retry then raises sw_en after WAKE_TICKS more ticks.
- R8: An oc_err or over-temperature fault holds fault_n at 0 for HOT_HOLD_TICKS ticks. When dc_err and oc_err occur together, the longer hold applies.
- R9: The over-temperature flag sets when temp_code >= HOT_TRIP and clears only when temp_code <= HOT_TRIP-HOT_HYST. Between those levels, retries keep failing and sw_en stays 0.
- R10: Priority from highest to lowest is shutdown, fault, sleep, mute. A shutdown request during a sleep ramp keeps the running ramp count, and the block then ends in shutdown. A fault during a sleep ramp stops switching at the next edge. A fault during a shutdown ramp is ignored.
- R11: A shutdown request during a fault hold drives fault_n to 1 on the next edge and keeps sw_en at 0 until shutdown is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ms_tick | input | 1 | One-cycle strobe per millisecond |
| shdn_pin_n | input | 1 | Shutdown pin, 0 requests shutdown |
| shdn_reg_n | input | 1 | Shutdown register bit, 0 requests shutdown |
| sleep_req | input | 1 | Sleep request |
| mute_req | input | 1 | Mute request |
| dc_err | input | 1 | DC error flag from the output stage |
| oc_err | input | 1 | Overcurrent flag from the output stage |
| temp_code | input | TEMP_W | Die temperature code |
| sw_en | output | 1 | Output stage switching enable |
| vol_up | output | 1 | 1: ramp volume to its setting, 0: ramp to minimum |
| fault_n | output | 1 | Active-low fault, low during a fault hold |

## Verification
The bench runs the block in a small configuration and sweeps all four combinations of the shutdown pin and the shutdown register bit, which shows whether the release requires both sources. It measures the exact tick counts on each path: power-up, shutdown ramp, sleep ramp, wake, and each fault hold. These counts separate the different entry and exit delays, and they show that the extra guard strobe applies only on the way down. It walks the temperature code across the trip level and inside the hysteresis band, which shows whether the flag trips and clears at the right levels. It also overlaps requests (shutdown during a sleep ramp, a fault during either ramp, shutdown during a fault hold) to confirm the priority order and that a running ramp count is kept.

// File: rtl/amp_seq_pkg.sv
package amp_seq_pkg;

  typedef enum logic [2:0] {
    MS_SHUT,
    MS_POWERUP,
    MS_PLAY,
    MS_RAMPDN,
    MS_SLEEP,
    MS_WAKE,
    MS_FAULT
  } mode_e;

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/amp_tick_timer.sv
module amp_tick_timer #(
  parameter int CW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          clr,
  input  logic [CW-1:0] limit,
  output logic          done
);

  logic [CW-1:0] cnt;

  // done fires on the tick that completes 'limit' counted ticks
  assign done = tick && (cnt == limit - CW'(1));

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (tick)  cnt <= cnt + CW'(1);
  end

endmodule

// File: rtl/amp_ot_detect.sv
module amp_ot_detect #(
  parameter int TEMP_W   = 8,
  parameter int HOT_TRIP = 150,
  parameter int HOT_HYST = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TEMP_W-1:0] temp_code,
  output logic              hot
);

  localparam logic [TEMP_W-1:0] TRIP_LVL = TEMP_W'(HOT_TRIP);
  localparam logic [TEMP_W-1:0] CLR_LVL  = TEMP_W'(HOT_TRIP - HOT_HYST);

  always_ff @(posedge clk) begin
    if (rst)      hot <= 1'b0;
    else if (hot) hot <= (temp_code > CLR_LVL);
    else          hot <= (temp_code >= TRIP_LVL);
  end

endmodule

// File: rtl/amp_mode_fsm.sv
module amp_mode_fsm
  import amp_seq_pkg::*;
#(
  parameter int CW             = 11,
  parameter int RAMP_TICKS     = 10,
  parameter int GUARD_TICKS    = 1,
  parameter int ACTIVE_TICKS   = 25,
  parameter int WAKE_TICKS     = 1,
  parameter int DC_HOLD_TICKS  = 650,
  parameter int HOT_HOLD_TICKS = 1300
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          shut_req,
  input  logic          flt_dc,
  input  logic          flt_hot,
  input  logic          sleep_req,
  input  logic          mute_req,
  input  logic          tmr_done,
  output logic          tmr_clr,
  output logic [CW-1:0] tmr_limit,
  output logic          sw_en,
  output logic          vol_up,
  output logic          fault_n
);

  mode_e st, nxt;
  logic  ramp_to_shut;
  logic  hold_long;
  logic  flt_any;

  assign flt_any = flt_dc || flt_hot;

  always_comb begin
    nxt = st;
    unique case (st)
      MS_SHUT:    if (!shut_req) nxt = MS_POWERUP;
      MS_POWERUP: begin
        if (shut_req)      nxt = MS_SHUT;
        else if (flt_any)  nxt = MS_FAULT;
        else if (tmr_done) nxt = MS_PLAY;
      end
      MS_PLAY: begin
        if (shut_req)       nxt = MS_RAMPDN;
        else if (flt_any)   nxt = MS_FAULT;
        else if (sleep_req) nxt = MS_RAMPDN;
      end
      MS_RAMPDN: begin
        if (!ramp_to_shut && !shut_req && flt_any) nxt = MS_FAULT;
        else if (tmr_done) nxt = (ramp_to_shut || shut_req) ? MS_SHUT : MS_SLEEP;
      end
      MS_SLEEP: begin
        if (shut_req)        nxt = MS_SHUT;
        else if (flt_any)    nxt = MS_FAULT;
        else if (!sleep_req) nxt = MS_WAKE;
      end
      MS_WAKE: begin
        if (shut_req)       nxt = MS_SHUT;
        else if (flt_any)   nxt = MS_FAULT;
        else if (sleep_req) nxt = MS_SLEEP;
        else if (tmr_done)  nxt = MS_PLAY;
      end
      MS_FAULT: begin
        if (shut_req)      nxt = MS_SHUT;
        else if (tmr_done) nxt = MS_WAKE;
      end
      default: nxt = MS_SHUT;
    endcase
  end

  assign tmr_clr = (nxt != st);

  always_comb begin
    unique case (st)
      MS_POWERUP: tmr_limit = CW'(ACTIVE_TICKS);
      MS_RAMPDN:  tmr_limit = CW'(RAMP_TICKS + GUARD_TICKS);
      MS_WAKE:    tmr_limit = CW'(WAKE_TICKS);
      MS_FAULT:   tmr_limit = hold_long ? CW'(HOT_HOLD_TICKS) : CW'(DC_HOLD_TICKS);
      default:    tmr_limit = CW'(1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= MS_SHUT;
      ramp_to_shut <= 1'b0;
      hold_long    <= 1'b0;
      sw_en        <= 1'b0;
      vol_up       <= 1'b0;
      fault_n      <= 1'b1;
    end else begin
      st <= nxt;
      if (nxt == MS_RAMPDN)
        ramp_to_shut <= (st == MS_RAMPDN) ? (ramp_to_shut || shut_req) : shut_req;
      else
        ramp_to_shut <= 1'b0;
      if (nxt == MS_FAULT && st != MS_FAULT)
        hold_long <= flt_hot;
      sw_en   <= (nxt == MS_PLAY) || (nxt == MS_RAMPDN);
      vol_up  <= (nxt == MS_PLAY) && !mute_req;
      fault_n <= (nxt != MS_FAULT);
    end
  end

endmodule

// File: rtl/amp_mode_seq.sv
module amp_mode_seq
  import amp_seq_pkg::*;
#(
  parameter int RAMP_TICKS     = 10,
  parameter int GUARD_TICKS    = 1,
  parameter int ACTIVE_TICKS   = 25,
  parameter int WAKE_TICKS     = 1,
  parameter int DC_HOLD_TICKS  = 650,
  parameter int HOT_HOLD_TICKS = 1300,
  parameter int TEMP_W         = 8,
  parameter int HOT_TRIP       = 150,
  parameter int HOT_HYST       = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ms_tick,
  input  logic              shdn_pin_n,
  input  logic              shdn_reg_n,
  input  logic              sleep_req,
  input  logic              mute_req,
  input  logic              dc_err,
  input  logic              oc_err,
  input  logic [TEMP_W-1:0] temp_code,
  output logic              sw_en,
  output logic              vol_up,
  output logic              fault_n
);

  localparam int MAX_LIM = max_int(max_int(RAMP_TICKS + GUARD_TICKS, ACTIVE_TICKS),
                                   max_int(max_int(WAKE_TICKS, DC_HOLD_TICKS), HOT_HOLD_TICKS));
  localparam int CW = $clog2(MAX_LIM + 1);

  logic          shut_req;
  logic          ot_hot;
  logic          tmr_clr;
  logic          tmr_done;
  logic [CW-1:0] tmr_limit;

  assign shut_req = !shdn_pin_n || !shdn_reg_n;

  amp_ot_detect #(
    .TEMP_W  (TEMP_W),
    .HOT_TRIP(HOT_TRIP),
    .HOT_HYST(HOT_HYST)
  ) u_ot (
    .clk      (clk),
    .rst      (rst),
    .temp_code(temp_code),
    .hot      (ot_hot)
  );

  amp_tick_timer #(.CW(CW)) u_tmr (
    .clk  (clk),
    .rst  (rst),
    .tick (ms_tick),
    .clr  (tmr_clr),
    .limit(tmr_limit),
    .done (tmr_done)
  );

  amp_mode_fsm #(
    .CW            (CW),
    .RAMP_TICKS    (RAMP_TICKS),
    .GUARD_TICKS   (GUARD_TICKS),
    .ACTIVE_TICKS  (ACTIVE_TICKS),
    .WAKE_TICKS    (WAKE_TICKS),
    .DC_HOLD_TICKS (DC_HOLD_TICKS),
    .HOT_HOLD_TICKS(HOT_HOLD_TICKS)
  ) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .shut_req (shut_req),
    .flt_dc   (dc_err),
    .flt_hot  (oc_err || ot_hot),
    .sleep_req(sleep_req),
    .mute_req (mute_req),
    .tmr_done (tmr_done),
    .tmr_clr  (tmr_clr),
    .tmr_limit(tmr_limit),
    .sw_en    (sw_en),
    .vol_up   (vol_up),
    .fault_n  (fault_n)
  );

endmodule

// File: rtl/amp_mode_seq_chk.sv
module amp_mode_seq_chk (
  input logic clk,
  input logic rst,
  input logic shdn_pin_n,
  input logic shdn_reg_n,
  input logic sleep_req,
  input logic mute_req,
  input logic dc_err,
  input logic oc_err,
  input logic ot_hot,
  input logic sw_en,
  input logic vol_up,
  input logic fault_n
);

  logic shut_c;
  logic flt_c;
  assign shut_c = !shdn_pin_n || !shdn_reg_n;
  assign flt_c  = dc_err || oc_err || ot_hot;

  p_reset_quiet_r1: assert property (@(posedge clk) rst |=> (!sw_en && !vol_up && fault_n));

  p_no_start_in_shut_r2: assert property (@(posedge clk) disable iff (rst)
    (shut_c && !sw_en) |=> !sw_en);

  p_vol_drop_on_shut_r3: assert property (@(posedge clk) disable iff (rst)
    shut_c |=> !vol_up);

  p_sleep_ramp_r4: assert property (@(posedge clk) disable iff (rst)
    (sleep_req && !shut_c && !flt_c && vol_up) |=> (sw_en && !vol_up));

  p_vol_needs_sw_r6: assert property (@(posedge clk) disable iff (rst)
    vol_up |-> sw_en);

  p_mute_keeps_sw_r6: assert property (@(posedge clk) disable iff (rst)
    (vol_up && mute_req && !shut_c && !flt_c && !sleep_req) |=> (sw_en && !vol_up));

  p_fault_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    !fault_n |-> (!sw_en && !vol_up));

  p_fault_stops_r10: assert property (@(posedge clk) disable iff (rst)
    (flt_c && !shut_c && vol_up) |=> (!sw_en && !fault_n));

  p_shut_clears_fault_r11: assert property (@(posedge clk) disable iff (rst)
    shut_c |=> fault_n);

endmodule

bind amp_mode_seq amp_mode_seq_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .shdn_pin_n(shdn_pin_n),
  .shdn_reg_n(shdn_reg_n),
  .sleep_req (sleep_req),
  .mute_req  (mute_req),
  .dc_err    (dc_err),
  .oc_err    (oc_err),
  .ot_hot    (ot_hot),
  .sw_en     (sw_en),
  .vol_up    (vol_up),
  .fault_n   (fault_n)
);

// File: tb/amp_mode_seq_tb.sv
`timescale 1ns/1ps
module amp_mode_seq_tb;

  localparam int RAMP = 3;
  localparam int GRD  = 1;
  localparam int ACT  = 5;
  localparam int WAK  = 2;
  localparam int DCH  = 6;
  localparam int HOTH = 9;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] tcnt;
  logic       ms_tick;
  logic       shdn_pin_n = 1'b0, shdn_reg_n = 1'b0;
  logic       sleep_req = 1'b0, mute_req = 1'b0;
  logic       dc_err = 1'b0, oc_err = 1'b0;
  logic [7:0] temp_code = 8'd40;
  logic       sw_en, vol_up, fault_n;

  int total = 0;
  int bad   = 0;
  bit fin   = 0;

  always #10 clk = ~clk;

  always_ff @(posedge clk) begin
    if (rst) tcnt <= 2'd0;
    else     tcnt <= tcnt + 2'd1;
  end
  assign ms_tick = (tcnt == 2'd3);

  amp_mode_seq #(
    .RAMP_TICKS(RAMP), .GUARD_TICKS(GRD), .ACTIVE_TICKS(ACT), .WAKE_TICKS(WAK),
    .DC_HOLD_TICKS(DCH), .HOT_HOLD_TICKS(HOTH), .TEMP_W(8), .HOT_TRIP(150), .HOT_HYST(15)
  ) u_dut (
    .clk(clk), .rst(rst), .ms_tick(ms_tick), .shdn_pin_n(shdn_pin_n), .shdn_reg_n(shdn_reg_n),
    .sleep_req(sleep_req), .mute_req(mute_req), .dc_err(dc_err), .oc_err(oc_err),
    .temp_code(temp_code), .sw_en(sw_en), .vol_up(vol_up), .fault_n(fault_n)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wait_ticks(input int k);
    int n = 0;
    while (n < k) begin
      if (ms_tick) n++;
      step();
    end
  endtask

  // count ticks until the selected output (0: sw_en, 1: fault_n) equals v
  task automatic count_until(input int sel, input logic v, input int lim, output int n);
    logic cur;
    n = 0;
    forever begin
      if (ms_tick) n++;
      step();
      cur = (sel == 0) ? sw_en : fault_n;
      if (cur === v) break;
      if (n > lim) begin n = -1; break; end
    end
  endtask

  task automatic align();
    while (!ms_tick) step();
    step();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!fin) begin
      total++; bad++;
      $display("FAIL watchdog actual=expired expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n;
    @(negedge clk);
    repeat (4) step();
    chk("R1 reset sw_en", int'(sw_en), 0);
    chk("R1 reset vol_up", int'(vol_up), 0);
    chk("R1 reset fault_n", int'(fault_n), 1);
    rst = 1'b0;
    step();
    chk("R1 after reset sw_en", int'(sw_en), 0);

    // R2: every combination with a source still requesting shutdown
    for (int c = 0; c < 3; c++) begin
      shdn_pin_n = c[0];
      shdn_reg_n = c[1];
      wait_ticks(ACT + 2);
      chk($sformatf("R2 held off combo %0d", c), int'(sw_en), 0);
    end
    align();
    shdn_pin_n = 1'b1; shdn_reg_n = 1'b1;
    count_until(0, 1'b1, ACT + 4, n);
    chk("R2 power-up ticks", n, ACT);
    chk("R2 vol_up after power-up", int'(vol_up), 1);

    // R6 mute
    mute_req = 1'b1; step();
    chk("R6 mute vol_up", int'(vol_up), 0);
    wait_ticks(RAMP + 2);
    chk("R6 mute keeps sw_en", int'(sw_en), 1);
    mute_req = 1'b0; step();
    chk("R6 unmute vol_up", int'(vol_up), 1);

    // R4 sleep then R5 wake
    align();
    sleep_req = 1'b1; step();
    chk("R4 sleep vol_up", int'(vol_up), 0);
    chk("R4 sleep sw_en during ramp", int'(sw_en), 1);
    count_until(0, 1'b0, RAMP + GRD + 4, n);
    chk("R4 sleep ramp ticks", n, RAMP + GRD);
    sleep_req = 1'b0;
    count_until(0, 1'b1, WAK + 4, n);
    chk("R5 wake ticks", n, WAK);
    chk("R5 vol_up after wake", int'(vol_up), 1);

    // R3 shutdown by register bit
    align();
    shdn_reg_n = 1'b0; step();
    chk("R3 shutdown vol_up", int'(vol_up), 0);
    count_until(0, 1'b0, RAMP + GRD + 4, n);
    chk("R3 shutdown ramp ticks", n, RAMP + GRD);
    shdn_reg_n = 1'b1;
    count_until(0, 1'b1, ACT + 4, n);
    chk("R2 restart ticks", n, ACT);

    // R10 shutdown during sleep ramp keeps the count
    align();
    sleep_req = 1'b1;
    wait_ticks(2);
    shdn_pin_n = 1'b0;
    count_until(0, 1'b0, RAMP + GRD + 4, n);
    chk("R10 shared ramp remaining ticks", n, RAMP + GRD - 2);
    sleep_req = 1'b0;
    wait_ticks(WAK + 3);
    chk("R10 ends in shutdown", int'(sw_en), 0);
    shdn_pin_n = 1'b1;
    count_until(0, 1'b1, ACT + 4, n);
    chk("R10 shutdown exit ticks", n, ACT);

    // R10 fault during shutdown ramp is ignored
    align();
    shdn_reg_n = 1'b0;
    wait_ticks(1);
    dc_err = 1'b1; step(); dc_err = 1'b0;
    chk("R10 fault ignored fault_n", int'(fault_n), 1);
    chk("R10 fault ignored sw_en", int'(sw_en), 1);
    count_until(0, 1'b0, RAMP + GRD + 4, n);
    chk("R10 shutdown ramp completes", n, RAMP + GRD - 1);
    shdn_reg_n = 1'b1;
    count_until(0, 1'b1, ACT + 4, n);

    // R7 DC fault
    align();
    dc_err = 1'b1; step(); dc_err = 1'b0;
    chk("R7 dc fault_n", int'(fault_n), 0);
    chk("R7 dc sw_en", int'(sw_en), 0);
    count_until(1, 1'b1, DCH + 4, n);
    chk("R7 dc hold ticks", n, DCH);
    count_until(0, 1'b1, WAK + 4, n);
    chk("R7 retry wake ticks", n, WAK);

    // R8 overcurrent
    align();
    oc_err = 1'b1; step(); oc_err = 1'b0;
    chk("R8 oc fault_n", int'(fault_n), 0);
    count_until(1, 1'b1, HOTH + 4, n);
    chk("R8 oc hold ticks", n, HOTH);
    count_until(0, 1'b1, WAK + 4, n);

    // R8 both classes together
    align();
    oc_err = 1'b1; dc_err = 1'b1; step(); oc_err = 1'b0; dc_err = 1'b0;
    count_until(1, 1'b1, HOTH + 4, n);
    chk("R8 combined hold ticks", n, HOTH);
    count_until(0, 1'b1, WAK + 4, n);

    // R9 temperature hysteresis
    align();
    temp_code = 8'd149;
    wait_ticks(HOTH);
    chk("R9 below trip no fault", int'(fault_n), 1);
    chk("R9 below trip sw_en", int'(sw_en), 1);
    temp_code = 8'd150; step(); step();
    chk("R9 trip fault_n", int'(fault_n), 0);
    chk("R9 trip sw_en", int'(sw_en), 0);
    temp_code = 8'd136;
    wait_ticks(2 * (HOTH + WAK) + 3);
    chk("R9 inside band stays off", int'(sw_en), 0);
    temp_code = 8'd135;
    count_until(0, 1'b1, 2 * (HOTH + WAK) + 4, n);
    chk("R9 clear level recovers", int'(n >= 0), 1);
    temp_code = 8'd40;

    // R10 fault during sleep ramp
    align();
    sleep_req = 1'b1;
    wait_ticks(1);
    dc_err = 1'b1; step(); dc_err = 1'b0;
    chk("R10 fault over sleep sw_en", int'(sw_en), 0);
    chk("R10 fault over sleep fault_n", int'(fault_n), 0);
    count_until(1, 1'b1, DCH + 4, n);
    sleep_req = 1'b0;
    count_until(0, 1'b1, WAK + 8, n);
    chk("R10 recovers after sleep fault", int'(n >= 0), 1);

    // R11 shutdown during a fault hold
    align();
    oc_err = 1'b1; step(); oc_err = 1'b0;
    wait_ticks(2);
    shdn_pin_n = 1'b0; step();
    chk("R11 fault_n released", int'(fault_n), 1);
    chk("R11 sw_en off", int'(sw_en), 0);
    wait_ticks(HOTH + 2);
    chk("R11 stays shut", int'(sw_en), 0);
    shdn_pin_n = 1'b1;
    count_until(0, 1'b1, ACT + 4, n);
    chk("R11 shutdown exit ticks", n, ACT);

    fin = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule